// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Change Interrupt

This block is the register core of an eight-pin general purpose I/O port of the kind that sits behind a serial expander. A simple register port (address, write data, write and read strobes, combinational read data) reaches seven byte-wide locations. Through them the port sets each pin's direction and output level, reads the pins back with an optional per-pin inversion, masks per-pin change interrupts, and picks for each pin either a bus-hold keeper or a pull resistor with a chosen direction. The keeper and pull choices leave the block as enable bits for the pad cell. The pad drivers and the resistors themselves sit outside this block.

Pin levels pass through a two-stage synchronizer. The synchronized value is compared against a snapshot taken at the last read of the pin location. Any difference on a pin that is an input and is not masked drives the interrupt output. That output is a drive-low enable, so it can be wired as an open-drain request line. It clears when software reads the pin location or when the pins return to the snapshot level.

Top module: `gpio_irq_port`

## Requirements
- R1: Location 2 holds the direction, one bit per pin, where 1 means input. `padOe` equals the inverse of that register one clock edge after the write.
- R2: While `rstN` is low and after it is released, direction and mask (location 4) read 0xFF, all other registers read 0x00, `padOe` is 0x00 and `irqDrvLow` is 0.
- R3: Reading location 0 returns the pin levels, taken two clock edges after they settle, XORed with the inversion register at location 1.
- R4: `irqDrvLow` is 1 while any input pin that is not masked has a synchronized level that differs from the snapshot.
- R5: A set bit in the mask register at location 4 stops that pin from driving the interrupt. When the bit is clear, the pin's changes are seen.
- R6: A read strobe at location 0 loads the snapshot with the synchronized levels, which clears the interrupt. The interrupt also clears, with no read, when the pins return to the snapshot levels.
- R7: `padOut` equals the output register at location 3 one edge after the write.
- R8: A level change on a pin set as an output never asserts the interrupt.
- R9: When a pin change reaches the synchronizer output on the same edge as a read of location 0, the snapshot takes the pre-change level and the interrupt stays asserted.
- R10: Location 5 enables the keeper (`keepEn`). Location 6 selects the pull direction (1 = up). `pullUpEn` and `pullDnEn` are active only for pins whose keeper is off.
- R11: Writes to location 0 and location 7 change no register. Location 7 reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe (only location 0 acts on it) |
| addr | input | 3 | Register location |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for `addr` |
| padIn | input | 8 | Pin levels from the pads |
| padOe | output | 8 | Per-pin output enable |
| padOut | output | 8 | Per-pin output level |
| keepEn | output | 8 | Per-pin keeper enable |
| pullUpEn | output | 8 | Per-pin pull-up enable |
| pullDnEn | output | 8 | Per-pin pull-down enable |
| irqDrvLow | output | 1 | Interrupt line drive-low enable |

## Verification
The read that loads the snapshot and a fresh pin change can land on the same clock edge. The bench provokes this by changing an unmasked input one cycle before it strobes a read of location 0, so the new level leaves the synchronizer on the read's own edge. After that edge it expects the interrupt still asserted. It then returns the pin to its old level and expects the interrupt to drop without a further read, which shows that the snapshot took the pre-change value.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_PINS   = 3'd0,
    REG_INVERT = 3'd1,
    REG_DIR    = 3'd2,
    REG_DRIVE  = 3'd3,
    REG_MASK   = 3'd4,
    REG_KEEP   = 3'd5,
    REG_PULL   = 3'd6,
    REG_SPARE  = 3'd7
  } regAddr_e;

  // configuration register slots inside the datapath
  localparam int CFG_N      = 6;
  localparam int CFG_INVERT = 0;
  localparam int CFG_DIR    = 1;
  localparam int CFG_DRIVE  = 2;
  localparam int CFG_MASK   = 3;
  localparam int CFG_KEEP   = 4;
  localparam int CFG_PULL   = 5;

  typedef struct packed {
    logic [CFG_N-1:0] wrCfg;   // one write strobe per configuration slot
    logic             rdPins;  // read of the pin location (snapshot load)
    regAddr_e         rdSel;   // read mux select
  } portStrobe_t;

  function automatic bit cfgResetsHigh(input int slot);
    return (slot == CFG_DIR) || (slot == CFG_MASK);
  endfunction

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output portStrobe_t       strb
);

  regAddr_e addrSel;
  assign addrSel = regAddr_e'(addr);

  always_comb begin
    strb        = '0;
    strb.rdSel  = addrSel;
    strb.rdPins = rdEn && (addrSel == REG_PINS);
    if (wrEn) begin
      case (addrSel)
        REG_INVERT: strb.wrCfg[CFG_INVERT] = 1'b1;
        REG_DIR:    strb.wrCfg[CFG_DIR]    = 1'b1;
        REG_DRIVE:  strb.wrCfg[CFG_DRIVE]  = 1'b1;
        REG_MASK:   strb.wrCfg[CFG_MASK]   = 1'b1;
        REG_KEEP:   strb.wrCfg[CFG_KEEP]   = 1'b1;
        REG_PULL:   strb.wrCfg[CFG_PULL]   = 1'b1;
        default:    ;  // pin location is read-only, spare location unused
      endcase
    end
  end

endmodule

// File: rtl/gpio_port_cfgreg.sv
module gpio_port_cfgreg #(
  parameter int WIDTH    = 8,
  parameter bit RST_ONES = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             we,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  localparam logic [WIDTH-1:0] RST_VAL = RST_ONES ? '1 : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)   q <= RST_VAL;
    else if (we) q <= d;
  end

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= '0;
        else       stageQ[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= '0;
        else       stageQ[g] <= stageQ[g-1];
      end
    end
  end

  assign q = stageQ[STAGES-1];

endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int PINS        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  portStrobe_t     strb,
  input  logic [PINS-1:0] wrData,
  input  logic [PINS-1:0] padIn,
  output logic [PINS-1:0] rdData,
  output logic [PINS-1:0] padOe,
  output logic [PINS-1:0] padOut,
  output logic [PINS-1:0] keepEn,
  output logic [PINS-1:0] pullUpEn,
  output logic [PINS-1:0] pullDnEn,
  output logic            irqDrvLow
);

  logic [PINS-1:0] cfgQ [CFG_N];
  logic [PINS-1:0] syncQ;
  logic [PINS-1:0] snapQ;
  logic [PINS-1:0] viewQ;
  logic [PINS-1:0] armed;
  logic [PINS-1:0] changed;

  for (genvar g = 0; g < CFG_N; g++) begin : g_cfg
    gpio_port_cfgreg #(
      .WIDTH    (PINS),
      .RST_ONES (cfgResetsHigh(g))
    ) u_cfg (
      .clk  (clk),
      .rstN (rstN),
      .we   (strb.wrCfg[g]),
      .d    (wrData),
      .q    (cfgQ[g])
    );
  end

  gpio_port_sync #(
    .WIDTH  (PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .d    (padIn),
    .q    (syncQ)
  );

  // snapshot taken at each read of the pin location
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            snapQ <= '0;
    else if (strb.rdPins) snapQ <= syncQ;
  end

  assign viewQ     = syncQ ^ cfgQ[CFG_INVERT];
  assign armed     = cfgQ[CFG_DIR] & ~cfgQ[CFG_MASK];
  assign changed   = (syncQ ^ snapQ) & armed;
  assign irqDrvLow = |changed;

  assign padOe    = ~cfgQ[CFG_DIR];
  assign padOut   = cfgQ[CFG_DRIVE];
  assign keepEn   = cfgQ[CFG_KEEP];
  assign pullUpEn = ~cfgQ[CFG_KEEP] & cfgQ[CFG_PULL];
  assign pullDnEn = ~cfgQ[CFG_KEEP] & ~cfgQ[CFG_PULL];

  always_comb begin
    case (strb.rdSel)
      REG_PINS:   rdData = viewQ;
      REG_INVERT: rdData = cfgQ[CFG_INVERT];
      REG_DIR:    rdData = cfgQ[CFG_DIR];
      REG_DRIVE:  rdData = cfgQ[CFG_DRIVE];
      REG_MASK:   rdData = cfgQ[CFG_MASK];
      REG_KEEP:   rdData = cfgQ[CFG_KEEP];
      REG_PULL:   rdData = cfgQ[CFG_PULL];
      default:    rdData = '0;
    endcase
  end

  // R6
  snap_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdPins |=> (!irqDrvLow || (syncQ != $past(syncQ))));

  // R8
  out_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(cfgQ[CFG_DIR]) && $stable(cfgQ[CFG_MASK]) && $stable(snapQ) &&
     (((syncQ ^ $past(syncQ)) & cfgQ[CFG_DIR]) == '0))
    |-> (irqDrvLow == $past(irqDrvLow)));

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_port_pkg::*;
#(
  parameter int PINS        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PINS-1:0]   wrData,
  output logic [PINS-1:0]   rdData,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOe,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   keepEn,
  output logic [PINS-1:0]   pullUpEn,
  output logic [PINS-1:0]   pullDnEn,
  output logic              irqDrvLow
);

  portStrobe_t strb;

  gpio_port_ctrl u_ctrl (
    .wrEn (wrEn),
    .rdEn (rdEn),
    .addr (addr),
    .strb (strb)
  );

  gpio_port_dp #(
    .PINS        (PINS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .padIn     (padIn),
    .rdData    (rdData),
    .padOe     (padOe),
    .padOut    (padOut),
    .keepEn    (keepEn),
    .pullUpEn  (pullUpEn),
    .pullDnEn  (pullDnEn),
    .irqDrvLow (irqDrvLow)
  );

  // R1
  dir_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr_e'(addr) == REG_DIR) |=> (padOe == ~$past(wrData)));

  // R5
  all_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr_e'(addr) == REG_MASK && wrData == '1) |=> !irqDrvLow);

  // R7
  drive_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr_e'(addr) == REG_DRIVE) |=> (padOut == $past(wrData)));

  // R10
  keep_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr_e'(addr) == REG_KEEP) |=>
      ((keepEn == $past(wrData)) && ((keepEn & (pullUpEn | pullDnEn)) == '0)));

  // R2
  always @(posedge clk) begin
    if (!rstN) begin
      reset_state_chk: assert (padOe == '0 && !irqDrvLow && padOut == '0);
    end
  end

endmodule

// File: tb/gpio_irq_port_test.sv
`timescale 1ns/1ps
module gpio_irq_port_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b1;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] padIn = 8'h00;
  logic [7:0] rdData, padOe, padOut, keepEn, pullUpEn, pullDnEn;
  logic       irqDrvLow;

  always #2.5 clk = ~clk;

  gpio_irq_port uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .padIn(padIn), .padOe(padOe),
    .padOut(padOut), .keepEn(keepEn), .pullUpEn(pullUpEn),
    .pullDnEn(pullDnEn), .irqDrvLow(irqDrvLow)
  );

  localparam int OBS_RD = 0, OBS_IRQ = 1, OBS_OE = 2, OBS_OUT = 3,
                 OBS_KEEP = 4, OBS_UP = 5, OBS_DN = 6;

  typedef struct {
    int         sel;
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t sbQ[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  function automatic logic [7:0] observe(input int sel);
    case (sel)
      OBS_RD:   return rdData;
      OBS_IRQ:  return {7'd0, irqDrvLow};
      OBS_OE:   return padOe;
      OBS_OUT:  return padOut;
      OBS_KEEP: return keepEn;
      OBS_UP:   return pullUpEn;
      default:  return pullDnEn;
    endcase
  endfunction

  // monitor: pops one expected item per falling edge
  always @(negedge clk) begin
    item_t      it;
    logic [7:0] act;
    if (sbQ.size() != 0 && !done) begin
      it  = sbQ.pop_front();
      act = observe(it.sel);
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s obs %0d actual %h expected %h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic expectObs(input int sel, input logic [7:0] exp, input string req);
    sbQ.push_back('{sel, exp, req});
    @(negedge clk); #0.5;
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); #0.5;
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); #0.5;
    wrEn = 1'b0;
  endtask

  task automatic readPins();
    @(negedge clk); #0.5;
    rdEn = 1'b1; addr = 3'd0;
    @(negedge clk); #0.5;
    rdEn = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, input logic [7:0] exp, input string req);
    addr = a;
    expectObs(OBS_RD, exp, req);
  endtask

  task automatic setPins(input logic [7:0] v);
    padIn = v;
    repeat (3) @(negedge clk);
    #0.5;
  endtask

  task automatic pulseReset();
    @(negedge clk); #0.5;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    #0.5;
    rstN = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1 rstN = 1'b0;
    repeat (3) @(negedge clk);
    // reset state while held (R2)
    #0.5;
    expectObs(OBS_OE, 8'h00, "R2");
    expectObs(OBS_IRQ, 8'h00, "R2");
    rstN = 1'b1;
    expectObs(OBS_OUT, 8'h00, "R2");
    expectObs(OBS_KEEP, 8'h00, "R2");
    expectObs(OBS_UP, 8'h00, "R10");
    expectObs(OBS_DN, 8'hFF, "R10");
    peek(3'd2, 8'hFF, "R2");
    peek(3'd4, 8'hFF, "R2");
    peek(3'd1, 8'h00, "R2");

    // pin readback and inversion (R3), default masking (R5)
    setPins(8'hA5);
    peek(3'd0, 8'hA5, "R3");
    expectObs(OBS_IRQ, 8'h00, "R5");
    writeReg(3'd1, 8'h0F);
    peek(3'd0, 8'hAA, "R3");
    peek(3'd1, 8'h0F, "R3");

    // change interrupt and its clearing (R4, R6)
    readPins();
    writeReg(3'd4, 8'h00);
    expectObs(OBS_IRQ, 8'h00, "R4");
    setPins(8'hA4);
    expectObs(OBS_IRQ, 8'h01, "R4");
    setPins(8'hA5);
    expectObs(OBS_IRQ, 8'h00, "R6");
    setPins(8'hA4);
    expectObs(OBS_IRQ, 8'h01, "R4");
    readPins();
    expectObs(OBS_IRQ, 8'h00, "R6");
    peek(3'd0, 8'hAB, "R3");

    // direction and output (R1, R7)
    writeReg(3'd2, 8'hF0);
    expectObs(OBS_OE, 8'h0F, "R1");
    writeReg(3'd3, 8'h3C);
    expectObs(OBS_OUT, 8'h3C, "R7");
    peek(3'd3, 8'h3C, "R7");

    // output pin changes stay quiet (R8)
    setPins(8'hA5);
    expectObs(OBS_IRQ, 8'h00, "R8");
    setPins(8'h25);
    expectObs(OBS_IRQ, 8'h01, "R4");
    readPins();
    expectObs(OBS_IRQ, 8'h00, "R6");

    // per-pin mask (R5)
    writeReg(3'd4, 8'h80);
    setPins(8'hA5);
    expectObs(OBS_IRQ, 8'h00, "R5");
    setPins(8'hE5);
    expectObs(OBS_IRQ, 8'h01, "R5");
    readPins();
    expectObs(OBS_IRQ, 8'h00, "R6");

    // change reaching the synchronizer output on the read edge (R9)
    @(negedge clk); #0.5;
    padIn = 8'hC5;
    @(negedge clk); #0.5;
    rdEn = 1'b1; addr = 3'd0;
    @(negedge clk); #0.5;
    rdEn = 1'b0;
    expectObs(OBS_IRQ, 8'h01, "R9");
    setPins(8'hE5);
    expectObs(OBS_IRQ, 8'h00, "R9");

    // keeper and pull selection (R10)
    writeReg(3'd5, 8'h0F);
    writeReg(3'd6, 8'h33);
    expectObs(OBS_KEEP, 8'h0F, "R10");
    expectObs(OBS_UP, 8'h30, "R10");
    expectObs(OBS_DN, 8'hC0, "R10");
    writeReg(3'd5, 8'h00);
    expectObs(OBS_UP, 8'h33, "R10");
    expectObs(OBS_DN, 8'hCC, "R10");

    // read-only and spare locations (R11)
    writeReg(3'd7, 8'hFF);
    writeReg(3'd0, 8'h00);
    peek(3'd7, 8'h00, "R11");
    peek(3'd0, 8'hEA, "R11");
    peek(3'd1, 8'h0F, "R11");
    peek(3'd2, 8'hF0, "R11");
    peek(3'd3, 8'h3C, "R11");
    peek(3'd4, 8'h80, "R11");
    peek(3'd5, 8'h00, "R11");
    peek(3'd6, 8'h33, "R11");
    expectObs(OBS_OE, 8'h0F, "R11");

    // reset in mid-run restores defaults (R2)
    pulseReset();
    expectObs(OBS_OE, 8'h00, "R2");
    expectObs(OBS_OUT, 8'h00, "R2");
    expectObs(OBS_IRQ, 8'h00, "R2");
    peek(3'd4, 8'hFF, "R2");
    peek(3'd1, 8'h00, "R2");
    peek(3'd0, 8'hE5, "R3");

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule